// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

The block collects interrupt requests from the functional blocks of several line ports, and from a few chip-wide sources, into one active-low interrupt pin. Each port's request lines are already masked by the leaf registers outside this block. Sources that belong to the line mode a port is not running in are gated off.

The block keeps two summary levels above the leaves. Each port has two summary bits. The common bit covers the performance-monitor update and the line interface. The group bit covers the framer, BERT, HDLC, FEAC and trail-trace blocks. The global summary tells software whether a pending interrupt is a chip-wide event, a chip-wide performance-monitor update, or comes from a port. A per-port pending vector tells it which port.

Software reads the global level, then the port level, then the leaf registers. Summary bits are combinational. The pin is fed by one register. The idle state of the pin is chosen by a configuration bit: it either floats or drives high.

Top module: `irq_tree_top`

## Requirements
- R1: While reset is asserted and right after it, with no source active, int_o is 1 and int_oe_o equals drive_high_i; with drive_high_i at 0 the pin floats.
- R2: For port p, port_sum_o[2p] is the OR of that port's common requests, cmn_req_i[2p+1:2p] (bit 0 PM update, bit 1 line interface), in the same cycle.
- R3: For port p, port_sum_o[2p+1] is the OR of the port's mode-allowed group requests blk_req_i[5p+4:5p] (bit 0 framer, 1 BERT, 2 HDLC, 3 FEAC, 4 trail trace), in the same cycle.
- R4: When port_e3_i[p] is 1 (E3), that port's FEAC request (group bit 3) is ignored. When port_e3_i[p] is 0 (DS3), its trail-trace request (group bit 4) is ignored. An ignored request reaches neither the summaries nor the pin.
- R5: port_pend_o[p] is the OR of the two summary bits of port p. glb_sum_o holds three bits: bit 0 is the OR of glb_evt_i, bit 1 is glb_pm_i, and bit 2 is the OR of port_pend_o. All of them follow the inputs in the same cycle.
- R6: When any bit of glb_sum_o is 1 at a rising clock edge, then after that edge int_o is 0 and int_oe_o is 1.
- R7: When glb_sum_o is 0 at a rising clock edge, then after that edge int_o is 1 and int_oe_o equals drive_high_i. A change of drive_high_i reaches int_oe_o without waiting for a clock edge.
- R8: Once all sources drop, the pin returns to its idle state after the next rising edge. A one-cycle pulse on any source produces exactly one cycle of active pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drive_high_i | input | 1 | 1: pin drives high when idle; 0: pin floats when idle |
| port_e3_i | input | N_PORTS | Per-port line mode, 1 = E3, 0 = DS3 |
| blk_req_i | input | N_PORTS*5 | Per-port group requests, 5 per port |
| cmn_req_i | input | N_PORTS*2 | Per-port common requests, 2 per port |
| glb_evt_i | input | N_GEV | Chip-wide event requests |
| glb_pm_i | input | 1 | Chip-wide performance-monitor update request |
| port_sum_o | output | N_PORTS*2 | Per-port summary: bit 2p common, bit 2p+1 group |
| port_pend_o | output | N_PORTS | Per-port pending |
| glb_sum_o | output | 3 | Global summary: event, PM update, port |
| int_o | output | 1 | Interrupt pin value, active low |
| int_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach is a port whose only active request belongs to the mode the port is not running in. It needs every other source idle at the same time, or the pin and summaries are busy anyway and hide the gating. The random stimulus keeps each request line sparse, so that fully idle and single-source cycles occur often, and directed cases place a lone FEAC or trail-trace request on one port in each mode. Directed pulses of one cycle and changes of the idle drive setting while the pin is idle cover the pin timing around release.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned N_BLK = 5;   // framer, bert, hdlc, feac, trail
  localparam int unsigned N_CMN = 2;   // pm update, line interface
  localparam int unsigned N_GSUM = 3;  // event, pm, port

  localparam int unsigned GSUM_EVT  = 0;
  localparam int unsigned GSUM_PM   = 1;
  localparam int unsigned GSUM_PORT = 2;

  // Allowed-source mask for a port in the given mode
  function automatic logic [N_BLK-1:0] mode_allow(input logic e3,
                                                  input logic [N_BLK-1:0] ds3_only,
                                                  input logic [N_BLK-1:0] e3_only);
    return e3 ? ~ds3_only : ~e3_only;
  endfunction
endpackage

// File: rtl/irq_port_node.sv
module irq_port_node
  import irq_agg_pkg::*;
#(
  parameter logic [N_BLK-1:0] DS3_ONLY = 5'b01000,
  parameter logic [N_BLK-1:0] E3_ONLY  = 5'b10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e3_i,
  input  logic [N_BLK-1:0] blk_i,
  input  logic [N_CMN-1:0] cmn_i,
  output logic             cmn_o,
  output logic             grp_o,
  output logic             pend_o
);
  logic [N_BLK-1:0] allowed;

  always_comb begin
    allowed = blk_i & mode_allow(e3_i, DS3_ONLY, E3_ONLY);
    cmn_o   = |cmn_i;
    grp_o   = |allowed;
    pend_o  = cmn_o | grp_o;
  end

  // R4: sources of the inactive mode never raise the group bit
  assert_gate_e3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e3_i && ((blk_i & ~DS3_ONLY) == '0)) |-> !grp_o);
  assert_gate_ds3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e3_i && ((blk_i & ~E3_ONLY) == '0)) |-> !grp_o);
endmodule

// File: rtl/irq_glb_node.sv
module irq_glb_node
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned N_GEV   = 4
) (
  input  logic [N_GEV-1:0]   evt_i,
  input  logic               pm_i,
  input  logic [N_PORTS-1:0] port_i,
  output logic [N_GSUM-1:0]  sum_o,
  output logic               any_o
);
  always_comb begin
    sum_o            = '0;
    sum_o[GSUM_EVT]  = |evt_i;
    sum_o[GSUM_PM]   = pm_i;
    sum_o[GSUM_PORT] = |port_i;
    any_o            = |sum_o;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic drive_high_i,
  output logic int_o,
  output logic int_oe_o
);
  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= any_i;
  end

  assign int_o    = ~act_q;
  assign int_oe_o = act_q | drive_high_i;

  assert_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_i |=> (!int_o && int_oe_o));
  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_i |=> (int_o && (int_oe_o == drive_high_i)));
  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_i) |=> int_o);
  always_comb if (!rst_ni) assert_reset_R1: assert (int_o);
endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned N_GEV   = 4,
  parameter logic [N_BLK-1:0] DS3_ONLY = 5'b01000,
  parameter logic [N_BLK-1:0] E3_ONLY  = 5'b10000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     drive_high_i,
  input  logic [N_PORTS-1:0]       port_e3_i,
  input  logic [N_PORTS*N_BLK-1:0] blk_req_i,
  input  logic [N_PORTS*N_CMN-1:0] cmn_req_i,
  input  logic [N_GEV-1:0]         glb_evt_i,
  input  logic                     glb_pm_i,
  output logic [N_PORTS*2-1:0]     port_sum_o,
  output logic [N_PORTS-1:0]       port_pend_o,
  output logic [N_GSUM-1:0]        glb_sum_o,
  output logic                     int_o,
  output logic                     int_oe_o
);
  logic any;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    irq_port_node #(.DS3_ONLY(DS3_ONLY), .E3_ONLY(E3_ONLY)) u_node (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .e3_i   (port_e3_i[p]),
      .blk_i  (blk_req_i[p*N_BLK +: N_BLK]),
      .cmn_i  (cmn_req_i[p*N_CMN +: N_CMN]),
      .cmn_o  (port_sum_o[2*p]),
      .grp_o  (port_sum_o[2*p+1]),
      .pend_o (port_pend_o[p])
    );
  end

  irq_glb_node #(.N_PORTS(N_PORTS), .N_GEV(N_GEV)) u_glb (
    .evt_i  (glb_evt_i),
    .pm_i   (glb_pm_i),
    .port_i (port_pend_o),
    .sum_o  (glb_sum_o),
    .any_o  (any)
  );

  irq_pin_drv u_pin (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .any_i        (any),
    .drive_high_i (drive_high_i),
    .int_o        (int_o),
    .int_oe_o     (int_oe_o)
  );

  // R5: port bit of the global level agrees with the port nodes
  assert_port_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_sum_o[GSUM_PORT] == (port_sum_o != '0));
endmodule

// File: tb/sim_irq_tree_top.sv
module sim_irq_tree_top;
  localparam int NP = 4;
  localparam int NG = 4;
  localparam logic [4:0] M_DS3 = 5'b01000; // FEAC only in DS3
  localparam logic [4:0] M_E3  = 5'b10000; // trail trace only in E3

  logic clk = 0, rst_ni = 0, drive_high = 0, glb_pm = 0;
  logic [NP-1:0] e3 = '0;
  logic [NP*5-1:0] blk = '0;
  logic [NP*2-1:0] cmn = '0;
  logic [NG-1:0] gev = '0;
  logic [NP*2-1:0] port_sum;
  logic [NP-1:0] port_pend;
  logic [2:0] glb_sum;
  logic int_o, int_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_tree_top #(.N_PORTS(NP), .N_GEV(NG)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .drive_high_i(drive_high), .port_e3_i(e3),
    .blk_req_i(blk), .cmn_req_i(cmn), .glb_evt_i(gev), .glb_pm_i(glb_pm),
    .port_sum_o(port_sum), .port_pend_o(port_pend), .glb_sum_o(glb_sum),
    .int_o(int_o), .int_oe_o(int_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP*2-1:0] exp_psum();
    logic [NP*2-1:0] r;
    for (int p = 0; p < NP; p++) begin
      logic [4:0] keep;
      keep = blk[p*5 +: 5] & (e3[p] ? ~M_DS3 : ~M_E3);
      r[2*p]   = |cmn[p*2 +: 2];
      r[2*p+1] = |keep;
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] exp_pend();
    logic [NP*2-1:0] s;
    logic [NP-1:0] r;
    s = exp_psum();
    for (int p = 0; p < NP; p++) r[p] = s[2*p] | s[2*p+1];
    return r;
  endfunction

  function automatic logic [2:0] exp_gsum();
    return {|exp_pend(), glb_pm, |gev};
  endfunction

  // Check summaries now, then pin after the next rising edge
  task automatic step_check(input string tag);
    logic act;
    #1;
    chk({tag, " R2 R3 port_sum"}, port_sum, exp_psum());
    chk({tag, " R5 port_pend"}, port_pend, exp_pend());
    chk({tag, " R5 glb_sum"}, glb_sum, exp_gsum());
    act = |exp_gsum();
    @(negedge clk);
    if (act) begin
      chk({tag, " R6 int"}, int_o, 0);
      chk({tag, " R6 oe"}, int_oe, 1);
    end else begin
      chk({tag, " R7 int"}, int_o, 1);
      chk({tag, " R7 oe"}, int_oe, drive_high);
    end
  endtask

  task automatic clear_all();
    blk = '0; cmn = '0; gev = '0; glb_pm = 0;
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    #3;
    chk("R1 reset int", int_o, 1);
    chk("R1 reset oe float", int_oe, 0);
    drive_high = 1; #1;
    chk("R1 reset oe drive", int_oe, 1);
    drive_high = 0;
    @(negedge clk); rst_ni = 1;
    @(negedge clk);
    chk("R1 after reset int", int_o, 1);
    chk("R1 after reset oe", int_oe, 0);

    // R4: lone FEAC in E3 on last port
    e3 = '1; blk[(NP-1)*5+3] = 1; step_check("R4 feac e3");
    chk("R4 feac e3 grp", port_sum[2*(NP-1)+1], 0);
    // FEAC in DS3 counts
    e3 = '0; step_check("R4 feac ds3");
    chk("R3 feac ds3 grp", port_sum[2*(NP-1)+1], 1);
    clear_all();
    // R4: lone trail trace in DS3 on port 0
    blk[4] = 1; step_check("R4 trail ds3");
    chk("R4 trail ds3 pin", int_o, 1);
    e3[0] = 1; step_check("R4 trail e3");
    chk("R3 trail e3 pin", int_o, 0);
    clear_all();
    step_check("R8 release");
    // R7: drive high config change while idle is immediate
    drive_high = 1; #1; chk("R7 oe immediate", int_oe, 1);
    step_check("R7 idle drive high");
    // R8: single-cycle pulse on global PM
    glb_pm = 1; #1; chk("R5 pm bit", glb_sum, 3'b010);
    @(negedge clk);
    chk("R8 pulse active", int_o, 0);
    glb_pm = 0;
    @(negedge clk);
    chk("R8 pulse one cycle", int_o, 1);
    chk("R8 pulse idle oe", int_oe, 1);
    // common source on port 2
    cmn[5] = 1; step_check("R2 liu port2");
    chk("R2 liu bit", port_sum, 8'b0001_0000);
    clear_all();
    gev[NG-1] = 1; step_check("R5 glb evt");
    clear_all();

    // Random sparse stimulus
    for (int i = 0; i < 400; i++) begin
      for (int b = 0; b < NP*5; b++) blk[b] = ($urandom % 16) == 0;
      for (int b = 0; b < NP*2; b++) cmn[b] = ($urandom % 16) == 0;
      for (int b = 0; b < NG; b++) gev[b] = ($urandom % 16) == 0;
      glb_pm = ($urandom % 16) == 0;
      e3 = NP'($urandom);
      if (($urandom % 8) == 0) drive_high = ~drive_high;
      step_check("rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R1 act=hung exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule